// File: doc/BRIEF.md
# Programmable READY Delay Generator

This block produces the READY half of a valid/ready handshake for one AXI channel. One copy is placed on each channel whose READY this side owns: write address and read address on the subordinate side, the write data channel, and the write response channel on the manager side (where BVALID is the watched signal). It watches the channel's VALID and decides, cycle by cycle, whether READY is high. It also drives a one-cycle handshake pulse for the payload logic next to it.

Two behaviours are chosen by a mode input. With the mode bit clear, READY rests low. After VALID appears, READY rises a programmed number of cycles later and stays up until the transfer completes. With the mode bit set, READY rests high, and the same programmed count instead sets how many cycles READY is pulled down after every completed transfer. For a zero delay in the first mode, a parameter chooses between a combinational READY that answers VALID in the same cycle and a registered READY one cycle later. A response reaches the manager in the first cycle where BREADY is high while BVALID is high, and that cycle is exactly where the handshake pulse fires.

Top module: `hs_ready_gen`

## Requirements
- R1: While reset is asserted READY is low. In the first cycle after reset is released, READY is low when the mode bit is 0 and high when it is 1.
- R2: Mode 0 with delay N >= 1: if VALID first goes high in cycle t while the block is idle, READY is low in cycles t to t+N-1 and high in cycle t+N.
- R3: Mode 0: when VALID is dropped during the wait, the count still runs to the end. Once READY is high it stays high until a handshake occurs, whatever VALID does.
- R4: Mode 0: in the cycle after a handshake READY is low. If VALID is still high in that cycle, a fresh delay of N cycles is counted from it.
- R5: Mode 0 with delay 0: when the ZERO_COMB parameter is 1, READY equals VALID in the same cycle. When it is 0, READY rises in the cycle after VALID rises.
- R6: Mode 1 with delay N >= 1: after a handshake in cycle h, READY is low in cycles h+1 to h+N and high again in cycle h+N+1, whatever VALID does.
- R7: Mode 1 with delay 0: READY stays high without a break across consecutive handshakes.
- R8: The handshake output is high in exactly those cycles where VALID and READY are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_dflt_rdy | input | 1 | Mode bit: 1 = READY rests high, 0 = READY rests low; change only during reset |
| cfg_delay | input | DLY_W | Programmed delay in cycles |
| valid_i | input | 1 | Channel VALID being watched |
| ready_o | output | 1 | Channel READY |
| hs_o | output | 1 | Handshake pulse (VALID and READY both high) |

## Verification
A wrong stored state shows at READY at once. An idle controller that believes it is open raises READY in the very cycle VALID arrives, rather than N cycles later. A controller stuck open in rest-high mode never shows the low window after a handshake. A count that is one too short or too long moves the READY edge by exactly one cycle. For that reason the bench compares READY and the handshake pulse in every cycle against expectations derived from the delay, and never only at the ends of transfers. Running a combinational and a registered zero-delay copy side by side pins down the one case in which the two differ.

// File: rtl/hrg_pkg.sv
package hrg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_OPEN = 2'd2
  } hrg_state_e;

  // Value loaded into the down counter when VALID arms a wait in rest-low mode.
  function automatic logic [31:0] arm_value(input logic [31:0] dly);
    return dly - 32'd1;
  endfunction

  // Delays of 0 (registered) and 1 open READY in the very next cycle.
  function automatic logic is_short(input logic [31:0] dly);
    return dly <= 32'd1;
  endfunction

endpackage

// File: rtl/hrg_delay_cnt.sv
module hrg_delay_cnt #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             tick,
  output logic             last_o
);

  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (load)                     cnt_q <= load_val;
    else if (tick && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == DLY_W'(1));

  // R6 / R2: the controller never waits on an empty counter
  a_r6_tick_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> cnt_q != '0);

  // R2: a ticking count moves down by exactly one each cycle
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt_q > DLY_W'(1)) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/hrg_ctrl.sv
module hrg_ctrl #(
  parameter int DLY_W     = 4,
  parameter bit ZERO_COMB = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dflt,
  input  logic [DLY_W-1:0] dly,
  input  logic             valid,
  input  logic             cnt_last,
  output logic             ready,
  output logic             hs,
  output logic             load,
  output logic [DLY_W-1:0] load_val,
  output logic             tick
);

  import hrg_pkg::*;

  hrg_state_e state_q, state_d;
  logic       idle_fast;
  logic       dly_zero;

  assign dly_zero  = (dly == '0);
  assign idle_fast = ZERO_COMB && !dflt && dly_zero && (state_q == ST_IDLE);
  assign ready     = rst_n && ((state_q == ST_OPEN) || (idle_fast && valid));
  assign hs        = valid && ready;
  assign tick      = (state_q == ST_WAIT);

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (dflt) begin
          state_d = ST_OPEN;
        end else if (valid && !hs) begin
          if (is_short(32'(dly))) begin
            state_d = ST_OPEN;
          end else begin
            load     = 1'b1;
            load_val = DLY_W'(arm_value(32'(dly)));
            state_d  = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (cnt_last) state_d = ST_OPEN;
      end
      ST_OPEN: begin
        if (hs) begin
          if (!dflt) begin
            state_d = ST_IDLE;
          end else if (!dly_zero) begin
            load     = 1'b1;
            load_val = dly;
            state_d  = ST_WAIT;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= dflt ? ST_OPEN : ST_IDLE;
    else        state_q <= state_d;
  end

  // R3: rest-low mode never retracts READY before a handshake
  a_r3_hold_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!dflt && ready && !valid) |=> ready);

  // R4: rest-low mode drops READY after a handshake with a nonzero delay
  a_r4_drop_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (!dflt && hs && !dly_zero) |=> !ready);

  // R2: a delay of two or more never opens READY on the next cycle
  a_r2_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    (!dflt && state_q == ST_IDLE && valid && dly > DLY_W'(1)) |=> !ready);

  // R6: rest-high mode pulls READY down after a handshake
  a_r6_low_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (dflt && hs && !dly_zero) |=> !ready);

  // R7: rest-high mode with zero delay stays open
  a_r7_stay_high: assert property (@(posedge clk) disable iff (!rst_n)
    (dflt && hs && dly_zero) |=> ready);

endmodule

// File: rtl/hs_ready_gen.sv
module hs_ready_gen #(
  parameter int DLY_W     = 4,
  parameter bit ZERO_COMB = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dflt_rdy,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             valid_i,
  output logic             ready_o,
  output logic             hs_o
);

  logic             cnt_load;
  logic [DLY_W-1:0] cnt_load_val;
  logic             cnt_tick;
  logic             cnt_last;

  hrg_ctrl #(
    .DLY_W     (DLY_W),
    .ZERO_COMB (ZERO_COMB)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .dflt     (cfg_dflt_rdy),
    .dly      (cfg_delay),
    .valid    (valid_i),
    .cnt_last (cnt_last),
    .ready    (ready_o),
    .hs       (hs_o),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .tick     (cnt_tick)
  );

  hrg_delay_cnt #(
    .DLY_W (DLY_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_load_val),
    .tick     (cnt_tick),
    .last_o   (cnt_last)
  );

  // R1: READY is low throughout reset
  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |-> !ready_o);

  // R8: a handshake pulse needs VALID and READY together
  a_r8_pulse_legal: assert property (@(posedge clk) disable iff (!rst_n)
    hs_o |-> (valid_i && ready_o));

endmodule

// File: tb/hs_ready_gen_tb_top.sv
module hs_ready_gen_tb_top;

  localparam int DLY_W = 4;

  typedef struct {
    logic  ra;
    logic  ha;
    logic  rb;
    logic  hb;
    string req;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_dflt_rdy = 1'b0;
  logic [DLY_W-1:0] cfg_delay = '0;
  logic             valid_i = 1'b0;
  logic             ready_a, hs_a, ready_b, hs_b;

  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;
  exp_t q[$];
  exp_t e;

  always #10 clk = ~clk;

  hs_ready_gen #(.DLY_W(DLY_W), .ZERO_COMB(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_dflt_rdy(cfg_dflt_rdy), .cfg_delay(cfg_delay),
    .valid_i(valid_i), .ready_o(ready_a), .hs_o(hs_a));

  hs_ready_gen #(.DLY_W(DLY_W), .ZERO_COMB(1'b0)) dut_reg_i (
    .clk(clk), .rst_n(rst_n), .cfg_dflt_rdy(cfg_dflt_rdy), .cfg_delay(cfg_delay),
    .valid_i(valid_i), .ready_o(ready_b), .hs_o(hs_b));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // monitor: pops one expectation per cycle, compares mid-cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(e.req, "ready(comb)", ready_a, e.ra);
      chk(e.req, "hs(comb)",    hs_a,    e.ha);
      chk(e.req, "ready(reg)",  ready_b, e.rb);
      chk(e.req, "hs(reg)",     hs_b,    e.hb);
    end
  end

  // driver: one cycle of stimulus plus its expected outputs
  task automatic step(input logic v, input logic ra, input logic ha,
                      input logic rb, input logic hb, input string req);
    exp_t x;
    @(posedge clk);
    #1;
    valid_i = v;
    x.ra = ra; x.ha = ha; x.rb = rb; x.hb = hb; x.req = req;
    q.push_back(x);
  endtask

  task automatic do_reset(input logic dflt, input logic [DLY_W-1:0] dly);
    exp_t x;
    for (int i = 0; i < 2; i++) begin
      @(posedge clk);
      #1;
      rst_n = 1'b0; valid_i = 1'b0; cfg_dflt_rdy = dflt; cfg_delay = dly;
      x.ra = 0; x.ha = 0; x.rb = 0; x.hb = 0; x.req = "R1";
      q.push_back(x);
    end
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    x.ra = dflt; x.ha = 0; x.rb = dflt; x.hb = 0; x.req = "R1";
    q.push_back(x);
  endtask

  initial begin
    // R1 + R2 + R4: rest-low mode, delay 3, VALID held through two transfers
    do_reset(1'b0, 4'd3);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R2");
    step(1, 1, 1, 1, 1, "R2");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R4");
    step(1, 1, 1, 1, 1, "R4");
    step(0, 0, 0, 0, 0, "R4");

    // R3: delay 4, VALID pulsed for one cycle then withdrawn
    cfg_delay = 4'd4;
    step(1, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R3");
    step(0, 1, 0, 1, 0, "R3");
    step(0, 1, 0, 1, 0, "R3");
    step(1, 1, 1, 1, 1, "R3");
    step(0, 0, 0, 0, 0, "R4");

    // R2: delay 1
    cfg_delay = 4'd1;
    step(1, 0, 0, 0, 0, "R2");
    step(1, 1, 1, 1, 1, "R2");
    step(0, 0, 0, 0, 0, "R2");

    // R5: delay 0, combinational versus registered copy
    cfg_delay = 4'd0;
    step(1, 1, 1, 0, 0, "R5");
    step(1, 1, 1, 1, 1, "R5");
    step(0, 0, 0, 0, 0, "R5");

    // R1 + R6 + R8: rest-high mode, delay 2
    do_reset(1'b1, 4'd2);
    step(0, 1, 0, 1, 0, "R8");
    step(1, 1, 1, 1, 1, "R8");
    step(1, 0, 0, 0, 0, "R6");
    step(1, 0, 0, 0, 0, "R6");
    step(1, 1, 1, 1, 1, "R6");
    step(0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 0, "R6");
    step(0, 1, 0, 1, 0, "R6");

    // R7: rest-high mode, delay 0, back-to-back transfers
    do_reset(1'b1, 4'd0);
    for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 1, "R7");
    step(0, 1, 0, 1, 0, "R7");

    // R1 + R2: rest-low mode after reset, delay 5
    do_reset(1'b0, 4'd5);
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, "R2");
    step(1, 1, 1, 1, 1, "R2");
    step(0, 0, 0, 0, 0, "R2");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule